// File: doc/BRIEF.md
# Signal Address Queue

This block sits at one processor's bus interface and takes in address-valued signals. A signal transaction appears on the bus with a valid strobe, a per-processor select line and an address. When both the strobe and this processor's select are high, the address is written into a local first-in first-out store. The processor is interrupted for as long as any address is waiting. It reads the oldest address from the head output and removes it with a one-cycle pop. Device interrupts use the same path, arriving as ordinary address-valued signals.

There is no flow control toward senders. A signal that arrives while the store is full is discarded. The discard sets a sticky overflow flag, which the processor clears with a one-cycle strobe, and it advances a saturating count of lost signals. If a pop and a capture arrive in the same cycle on a full store, the pop is taken first, so the new address is kept.

Top module: `sig_addr_queue`

## Requirements
- R1: A cycle with `sig_valid`=1 and `sig_sel`=1 on a store that is not full appends `sig_addr` at the tail. The store is one entry larger from the next clock edge onward.
- R2: A cycle in which `sig_valid` or `sig_sel` is 0 stores nothing, whatever `sig_addr` holds.
- R3: Entries leave oldest first. `head_addr` shows the oldest stored address whenever `irq`=1, and each `pop` with `irq`=1 removes exactly that entry.
- R4: `irq` is 1 exactly when the store holds at least one entry. It rises at the clock edge that stores into an empty store and falls at the edge that removes the last entry.
- R5: A `pop` while the store is empty has no effect: the store stays empty, and the next captured address becomes the head.
- R6: A capture on a full store (default depth 128) without a pop in the same cycle is discarded. The stored entries and their order are unchanged.
- R7: A capture and a `pop` in the same cycle on a full store both take effect. The head entry leaves, the new address goes to the tail, and nothing is counted as dropped.
- R8: `ovf_flag` becomes 1 at the edge after a discarded capture and holds until an `ovf_clear` cycle with no discard. If a discard and `ovf_clear` fall in the same cycle, the flag stays 1.
- R9: `drop_count` (default 8 bits) goes up by one for each discarded capture and stops at 255. `ovf_clear` does not change it.
- R10: After reset the store is empty, `irq`=0, `ovf_flag`=0 and `drop_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_valid | input | 1 | A signal transaction is on the bus this cycle |
| sig_sel | input | 1 | This processor is named as a recipient |
| sig_addr | input | ADDR_W | Physical address carried by the signal |
| pop | input | 1 | Processor removes the head entry |
| head_addr | output | ADDR_W | Oldest stored address, meaningful while irq=1 |
| irq | output | 1 | Interrupt: at least one address pending |
| ovf_clear | input | 1 | Processor strobe that clears the overflow flag |
| ovf_flag | output | 1 | Sticky: a signal has been discarded |
| drop_count | output | DROP_W | Saturating count of discarded signals |

## Verification
Every result of this block is due one clock edge after its stimulus. Captures, pops, discards and clears are all sampled at a rising edge, and `irq`, `head_addr`, `ovf_flag` and `drop_count` take their new values at that same edge. The bench changes inputs on the falling edge and checks outputs at the following falling edge. Each check therefore sees the state after exactly one rising edge. Order and discard checks read entries back through `head_addr` and `pop`, so an address that was wrongly stored or lost shows up when the store is drained.

// File: rtl/sigq_pkg.sv
package sigq_pkg;

  typedef struct packed {
    logic push;
    logic pop;
    logic drop;
  } q_ctl_t;

  // pointer advance with wrap at lim-1
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned lim);
    return (p + 1 >= lim) ? 0 : p + 1;
  endfunction

  // counter advance that stops at maxv
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned maxv);
    return (v >= maxv) ? maxv : v + 1;
  endfunction

endpackage

// File: rtl/sigq_decode.sv
module sigq_decode
  import sigq_pkg::*;
(
  input  logic   sig_valid,
  input  logic   sig_sel,
  input  logic   pop_req,
  input  logic   empty,
  input  logic   full,
  output q_ctl_t ctl
);

  logic hit;

  always_comb begin
    hit      = sig_valid & sig_sel;
    ctl.pop  = pop_req & ~empty;
    // a pop on a full store frees the slot first
    ctl.push = hit & (~full | ctl.pop);
    ctl.drop = hit & full & ~ctl.pop;
  end

endmodule

// File: rtl/sigq_store.sv
module sigq_store #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 128,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] head_addr,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count
);
  import sigq_pkg::*;

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(wrap_inc(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(wrap_inc(32'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_addr = mem[rd_ptr];
  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));

  // R1
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> count == $past(count) + 1'b1);

  // R3
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> count == $past(count) - 1'b1);

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

endmodule

// File: rtl/sigq_overflow.sv
module sigq_overflow #(
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drop,
  input  logic              clear,
  output logic              flag,
  output logic [DROP_W-1:0] drops
);
  import sigq_pkg::*;

  localparam int unsigned DROP_MAX = (1 << DROP_W) - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      drops <= '0;
    end else begin
      // a discard in the clearing cycle keeps the flag set
      if (drop)       flag <= 1'b1;
      else if (clear) flag <= 1'b0;
      if (drop) drops <= DROP_W'(sat_inc(32'(drops), DROP_MAX));
    end
  end

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> flag);

  // R9
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && drops != '1) |=> drops == $past(drops) + 1'b1);

  // R9
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drop |=> $stable(drops));

endmodule

// File: rtl/sig_addr_queue.sv
module sig_addr_queue #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 128,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_valid,
  input  logic              sig_sel,
  input  logic [ADDR_W-1:0] sig_addr,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic              irq,
  input  logic              ovf_clear,
  output logic              ovf_flag,
  output logic [DROP_W-1:0] drop_count
);
  import sigq_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);

  q_ctl_t           ctl;
  logic             q_empty, q_full;
  logic [CNT_W-1:0] q_count;

  sigq_decode u_decode (
    .sig_valid (sig_valid),
    .sig_sel   (sig_sel),
    .pop_req   (pop),
    .empty     (q_empty),
    .full      (q_full),
    .ctl       (ctl)
  );

  sigq_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ctl.push),
    .pop       (ctl.pop),
    .wr_addr   (sig_addr),
    .head_addr (head_addr),
    .empty     (q_empty),
    .full      (q_full),
    .count     (q_count)
  );

  sigq_overflow #(.DROP_W(DROP_W)) u_ovf (
    .clk   (clk),
    .rst_n (rst_n),
    .drop  (ctl.drop),
    .clear (ovf_clear),
    .flag  (ovf_flag),
    .drops (drop_count)
  );

  assign irq = ~q_empty;

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.push |=> irq);

  // R6
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.drop |=> ($stable(head_addr) && $stable(q_count)));

  // R2
  no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sig_valid && sig_sel) && !ctl.pop) |=> $stable(q_count));

endmodule

// File: tb/sig_addr_queue_tb.sv
module sig_addr_queue_tb_top;

  localparam int AW = 32;
  localparam int DEPTH = 128;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sig_valid = 1'b0, sig_sel = 1'b0, pop = 1'b0, ovf_clear = 1'b0;
  logic [AW-1:0] sig_addr = '0;
  logic [AW-1:0] head_addr;
  logic          irq, ovf_flag;
  logic [DW-1:0] drop_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sig_addr_queue dut_i (
    .clk(clk), .rst_n(rst_n), .sig_valid(sig_valid), .sig_sel(sig_sel),
    .sig_addr(sig_addr), .pop(pop), .head_addr(head_addr), .irq(irq),
    .ovf_clear(ovf_clear), .ovf_flag(ovf_flag), .drop_count(drop_count)
  );

  typedef struct packed {
    logic          v;
    logic          s;
    logic [AW-1:0] a;
    logic          p;
    logic          eirq;
    logic [AW-1:0] ehead;
  } vec_t;

  // R1 R2 R3 R4 R5 stimulus rows, results due one edge later
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    {1'b1, 1'b1, 32'h100, 1'b0, 1'b1, 32'h100},
    {1'b1, 1'b0, 32'h200, 1'b0, 1'b1, 32'h100},
    {1'b1, 1'b1, 32'h300, 1'b0, 1'b1, 32'h100},
    {1'b0, 1'b0, 32'h0,   1'b1, 1'b1, 32'h300},
    {1'b0, 1'b1, 32'h400, 1'b0, 1'b1, 32'h300},
    {1'b1, 1'b1, 32'h500, 1'b1, 1'b1, 32'h500},
    {1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 32'h0},
    {1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 32'h0},
    {1'b1, 1'b1, 32'h600, 1'b0, 1'b1, 32'h600},
    {1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 32'h0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [AW-1:0] a,
                      input logic p, input logic c);
    sig_valid = v; sig_sel = s; sig_addr = a; pop = p; ovf_clear = c;
    @(negedge clk);
    sig_valid = 1'b0; sig_sel = 1'b0; pop = 1'b0; ovf_clear = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(irq == 1'b0, "R10 irq", 32'(irq), 0);
    check(ovf_flag == 1'b0, "R10 ovf", 32'(ovf_flag), 0);
    check(drop_count == '0, "R10 drops", 32'(drop_count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].v, VEC[i].s, VEC[i].a, VEC[i].p, 1'b0);
      check(irq == VEC[i].eirq, "R4 irq row", 32'(irq), 32'(VEC[i].eirq));
      if (VEC[i].eirq)
        check(head_addr == VEC[i].ehead, "R3 head row", head_addr, VEC[i].ehead);
    end

    // R1 fill to capacity
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, 32'h1000 + i, 1'b0, 1'b0);
    check(irq == 1'b1, "R1 irq full", 32'(irq), 1);
    check(head_addr == 32'h1000, "R3 head full", head_addr, 32'h1000);
    check(ovf_flag == 1'b0, "R8 no ovf at full", 32'(ovf_flag), 0);

    // R6 discard on full
    step(1'b1, 1'b1, 32'hDEAD, 1'b0, 1'b0);
    check(ovf_flag == 1'b1, "R8 ovf set", 32'(ovf_flag), 1);
    check(drop_count == 8'd1, "R9 drop one", 32'(drop_count), 1);
    check(head_addr == 32'h1000, "R6 head kept", head_addr, 32'h1000);

    // R7 pop and capture together on full
    step(1'b1, 1'b1, 32'h2000, 1'b1, 1'b0);
    check(drop_count == 8'd1, "R7 no drop", 32'(drop_count), 1);
    check(head_addr == 32'h1001, "R7 head advanced", head_addr, 32'h1001);

    // R3 R6 R7 drain: 0x1001..0x107F then 0x2000, 0xDEAD absent
    for (int i = 1; i <= DEPTH; i++) begin
      logic [31:0] e;
      e = (i < DEPTH) ? 32'h1000 + i : 32'h2000;
      check(irq == 1'b1, "R4 irq drain", 32'(irq), 1);
      check(head_addr == e, "R3 drain order", head_addr, e);
      step(1'b0, 1'b0, '0, 1'b1, 1'b0);
    end
    check(irq == 1'b0, "R4 irq empty", 32'(irq), 0);
    check(ovf_flag == 1'b1, "R8 ovf sticky", 32'(ovf_flag), 1);

    // R8 clear, R9 count survives clear
    step(1'b0, 1'b0, '0, 1'b0, 1'b1);
    check(ovf_flag == 1'b0, "R8 ovf cleared", 32'(ovf_flag), 0);
    check(drop_count == 8'd1, "R9 count kept", 32'(drop_count), 1);

    // R8 discard and clear in one cycle
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, 32'h3000 + i, 1'b0, 1'b0);
    step(1'b1, 1'b1, 32'hBEEF, 1'b0, 1'b1);
    check(ovf_flag == 1'b1, "R8 set wins", 32'(ovf_flag), 1);
    check(drop_count == 8'd2, "R9 drop two", 32'(drop_count), 2);

    // R9 saturation
    for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 32'hF00D, 1'b0, 1'b0);
    check(drop_count == 8'd255, "R9 saturate", 32'(drop_count), 255);
    check(head_addr == 32'h3000, "R6 head after drops", head_addr, 32'h3000);
    step(1'b0, 1'b0, '0, 1'b1, 1'b0);
    check(head_addr == 32'h3001, "R3 pop after drops", head_addr, 32'h3001);
    check(drop_count == 8'd255, "R9 held", 32'(drop_count), 255);

    finish_run();
  end

endmodule